// File: doc/BRIEF.md
# Bit-Serial Four-Instruction Processor Core

This block is a very small 32-bit processor core. Its arithmetic and logic run one bit per clock. A single one-bit full adder keeps its carry in a flip-flop from one bit to the next. Beside it sits a one-bit NOR path. The core has one accumulator and no register file. Every other operand is an ordinary word in memory, named directly by the instruction that uses it.

Each instruction word is 32 bits. The top two bits select one of four operations: add a memory word to the accumulator, NOR a memory word into the accumulator, store the accumulator to memory, or jump when the accumulator is negative. The low 30 bits form the word address that the operation uses. The core talks to a word-wide synchronous memory through a request/ready handshake.

An instruction first fetches its word, then decodes it. Add and NOR then read their operand and shift through 32 bit-cycles, counted by a 6-bit microcycle counter. A final update cycle realigns the accumulator and advances the instruction pointer.

Top module: `bitser_core`

## Requirements
- R1: A synchronous active-high reset clears the instruction pointer, the accumulator, the carry flip-flop and the microcycle counter. While reset is held, the core presents a read request (`mem_req`=1, `mem_we`=0) for word address 0, with `mem_wdata`=0.
- R2: An instruction word carries its opcode in bits [31:30] and its operand word address in bits [29:0]. The encodings are 00 add, 01 NOR, 10 store, 11 jump-if-negative.
- R3: Add sets the accumulator to (accumulator + mem[a]) modulo 2^32. It works LSB first, and the carry flip-flop is cleared before bit 0. The carry out of bit 31 is discarded.
- R4: NOR sets the accumulator to the bitwise NOT of (accumulator OR mem[a]).
- R5: Store writes the accumulator to mem[a] and leaves the accumulator unchanged.
- R6: Jump-if-negative makes the next fetch address a when accumulator bit 31 is 1. When that bit is 0, the next fetch address is the instruction pointer plus 1.
- R7: Every instruction starts with one read at the instruction pointer. Add and NOR then make exactly one read at a. Store makes exactly one write at a. Jump-if-negative makes no further access.
- R8: The shift phase lasts exactly 32 cycles. Counting cycles with `mem_req` low, there is 1 cycle between a fetch and its operand read or write, 33 cycles after an add/NOR operand read, 1 cycle after a store write, and 2 cycles after the fetch of a jump.
- R9: Once raised, `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until a clock edge at which `mem_ready` is high. That edge completes the access, and read data is taken at that edge. Any number of wait cycles is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 30 | Word address |
| mem_wdata | output | 32 | Write data (accumulator) |
| mem_rdata | input | 32 | Read data, valid while mem_ready is high |
| mem_ready | input | 1 | Access completes at this clock edge |

## Verification
The assertions check on every cycle that the request stays stable until ready, that the carry is cleared at the start of each shift phase, and that the counter stays in range and ends the shift phase on its last step. They also check that the instruction pointer either steps by one or takes the jump target, and that writes happen only for a store. Arithmetic results are a different matter. Carry rippling across all 32 bits, dropping of the final carry, NOR patterns and the skipping of a store by a taken jump can only be shown by the bench. It runs a program and compares every memory access, with its address, data and idle gap, against a scoreboard of expected accesses, while the memory varies its wait states.

// File: rtl/bitser_pkg.sv
`timescale 1ns/1ps
package bitser_pkg;

    typedef enum logic [2:0] {
        PH_FETCH  = 3'd0,
        PH_DECODE = 3'd1,
        PH_OPND   = 3'd2,
        PH_SHIFT  = 3'd3,
        PH_WRITE  = 3'd4,
        PH_UPDATE = 3'd5
    } phase_e;

    // operation code in the top bits of an instruction word
    typedef enum logic [1:0] {
        OP_ADD    = 2'b00,
        OP_NOR    = 2'b01,
        OP_STORE  = 2'b10,
        OP_JMPNEG = 2'b11
    } opcode_e;

endpackage

// File: rtl/bitser_alu_slice.sv
`timescale 1ns/1ps
// One-bit arithmetic/logic slice: full adder or NOR
module bitser_alu_slice (
    input  logic a_bit,
    input  logic b_bit,
    input  logic carry_in,
    input  logic sel_nor,
    output logic res_bit,
    output logic carry_out
);
    logic half_sum;

    always_comb begin
        half_sum  = a_bit ^ b_bit;
        carry_out = (a_bit & b_bit) | (carry_in & half_sum);
        res_bit   = sel_nor ? ~(a_bit | b_bit) : (half_sum ^ carry_in);
    end
endmodule

// File: rtl/bitser_step_ctr.sv
`timescale 1ns/1ps
// Microcycle counter: counts 0..LAST while enabled, wraps to 0 after LAST
module bitser_step_ctr #(
    parameter int CNT_W = 6,
    parameter int LAST  = 31
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] count,
    output logic             last
);
    localparam logic [CNT_W-1:0] LAST_V = CNT_W'(LAST);
    localparam logic [CNT_W-1:0] STEP_V = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en) begin
            cnt_d = (cnt_q == LAST_V) ? '0 : cnt_q + STEP_V;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q;
    assign last  = (cnt_q == LAST_V);

    // R8: the count never leaves 0..LAST
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST_V);

    // R8: a clear always restarts the sequence at step 0
    p_cnt_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt_q == '0);
endmodule

// File: rtl/bitser_core.sv
`timescale 1ns/1ps
module bitser_core
    import bitser_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int OPC_W  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic                       mem_req,
    output logic                       mem_we,
    output logic [DATA_W-OPC_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]          mem_wdata,
    input  logic [DATA_W-1:0]          mem_rdata,
    input  logic                       mem_ready
);
    localparam int ADDR_W = DATA_W - OPC_W;
    localparam int CNT_W  = $clog2(DATA_W) + 1;
    localparam int LAST_STEP = DATA_W - 1;
    localparam logic [ADDR_W-1:0] IP_STEP = ADDR_W'(1);

    typedef struct packed {
        phase_e              phase;
        logic [ADDR_W-1:0]   ip;
        logic [ADDR_W-1:0]   mar;
        opcode_e             ir;
        logic [DATA_W:0]     acc;   // data bits plus one spill stage at the top
        logic [DATA_W-1:0]   opnd;  // fetched word / operand shift register
        logic                carry;
    } core_s;

    localparam core_s CORE_RST = '{
        phase: PH_FETCH, ip: '0, mar: '0, ir: OP_ADD,
        acc: '0, opnd: '0, carry: 1'b0
    };

    core_s r_q, r_d;

    logic             cnt_clr, cnt_en, cnt_last;
    logic [CNT_W-1:0] cnt_val;
    logic             alu_res, alu_cout;
    opcode_e          dec_op;
    logic             jump_take;

    bitser_step_ctr #(
        .CNT_W (CNT_W),
        .LAST  (LAST_STEP)
    ) u_step (
        .clk   (clk),
        .rst   (rst),
        .clr   (cnt_clr),
        .en    (cnt_en),
        .count (cnt_val),
        .last  (cnt_last)
    );

    bitser_alu_slice u_slice (
        .a_bit     (r_q.acc[0]),
        .b_bit     (r_q.opnd[0]),
        .carry_in  (r_q.carry),
        .sel_nor   (r_q.ir == OP_NOR),
        .res_bit   (alu_res),
        .carry_out (alu_cout)
    );

    always_comb begin
        r_d       = r_q;
        cnt_clr   = 1'b0;
        cnt_en    = 1'b0;
        dec_op    = opcode_e'(r_q.opnd[DATA_W-1 -: OPC_W]);
        jump_take = (r_q.ir == OP_JMPNEG) && r_q.acc[DATA_W-1];

        unique case (r_q.phase)
            PH_FETCH: begin
                if (mem_ready) begin
                    r_d.opnd  = mem_rdata;
                    r_d.phase = PH_DECODE;
                end
            end
            PH_DECODE: begin
                r_d.ir    = dec_op;
                r_d.mar   = r_q.opnd[ADDR_W-1:0];
                r_d.carry = 1'b0;
                cnt_clr   = 1'b1;
                unique case (dec_op)
                    OP_ADD, OP_NOR: r_d.phase = PH_OPND;
                    OP_STORE:       r_d.phase = PH_WRITE;
                    default:        r_d.phase = PH_UPDATE;
                endcase
            end
            PH_OPND: begin
                if (mem_ready) begin
                    r_d.opnd  = mem_rdata;
                    r_d.phase = PH_SHIFT;
                end
            end
            PH_SHIFT: begin
                cnt_en   = 1'b1;
                r_d.acc  = {alu_res, r_q.acc[DATA_W:1]};
                r_d.opnd = {1'b0, r_q.opnd[DATA_W-1:1]};
                if (r_q.ir == OP_ADD) r_d.carry = alu_cout;
                if (cnt_last) r_d.phase = PH_UPDATE;
            end
            PH_WRITE: begin
                if (mem_ready) r_d.phase = PH_UPDATE;
            end
            PH_UPDATE: begin
                if (r_q.ir == OP_ADD || r_q.ir == OP_NOR) begin
                    // result sits one place high after the last shift
                    r_d.acc = {1'b0, r_q.acc[DATA_W:1]};
                end
                r_d.ip    = jump_take ? r_q.mar : r_q.ip + IP_STEP;
                r_d.phase = PH_FETCH;
            end
            default: r_d.phase = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= CORE_RST;
        else     r_q <= r_d;
    end

    always_comb begin
        mem_req   = (r_q.phase == PH_FETCH) || (r_q.phase == PH_OPND) ||
                    (r_q.phase == PH_WRITE);
        mem_we    = (r_q.phase == PH_WRITE);
        mem_addr  = (r_q.phase == PH_FETCH) ? r_q.ip : r_q.mar;
        mem_wdata = r_q.acc[DATA_W-1:0];
    end

    // R1: state right after reset
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (r_q.ip == '0 && r_q.acc == '0 && !r_q.carry &&
                        cnt_val == '0 && mem_req && !mem_we && mem_addr == '0));

    // R9: request and its attributes hold until ready
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) &&
                                     $stable(mem_we) && $stable(mem_wdata)));

    // R3: carry starts at zero when the shift phase begins
    p_carry_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (r_q.phase == PH_OPND && mem_ready) |=> (r_q.phase == PH_SHIFT && !r_q.carry));

    // R6: taken jump loads the operand address
    p_jump_taken_r6: assert property (@(posedge clk) disable iff (rst)
        (r_q.phase == PH_UPDATE && r_q.ir == OP_JMPNEG && r_q.acc[DATA_W-1])
        |=> (r_q.ip == $past(r_q.mar) && mem_addr == $past(r_q.mar)));

    // R6: otherwise the pointer steps by one
    p_ip_step_r6: assert property (@(posedge clk) disable iff (rst)
        (r_q.phase == PH_UPDATE && !(r_q.ir == OP_JMPNEG && r_q.acc[DATA_W-1]))
        |=> r_q.ip == $past(r_q.ip) + IP_STEP);

    // R7: a jump makes no access after its fetch
    p_jump_no_access_r7: assert property (@(posedge clk) disable iff (rst)
        (r_q.phase == PH_DECODE && r_q.opnd[DATA_W-1 -: OPC_W] == OP_JMPNEG)
        |=> !mem_req);

    // R7: writes only come from a store
    p_write_only_store_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_req && r_q.ir == OP_STORE));

    // R8: last counted step ends the shift phase
    p_shift_end_r8: assert property (@(posedge clk) disable iff (rst)
        (r_q.phase == PH_SHIFT && cnt_last) |=> r_q.phase == PH_UPDATE);

    // R8: shift phase is not left early
    p_shift_stay_r8: assert property (@(posedge clk) disable iff (rst)
        (r_q.phase == PH_SHIFT && !cnt_last) |=> r_q.phase == PH_SHIFT);
endmodule

// File: tb/bitser_core_tb.sv
`timescale 1ns/1ps
module bitser_core_tb;
    localparam int AW = 30;
    localparam int DW = 32;
    localparam int MEM_N = 64;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mem_req, mem_we, mem_ready;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    always #10 clk = ~clk;   // 50 MHz

    bitser_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready)
    );

    typedef struct {
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int            gap;
        string         tag;
    } xact_t;

    xact_t         exp_q[$];
    logic [DW-1:0] mem [MEM_N];
    int            checks = 0;
    int            errors = 0;
    int            prev_gap = -1;
    bit            done = 1'b0;

    function automatic logic [DW-1:0] enc(input logic [1:0] op, input int a);
        return {op, AW'(a)};
    endfunction

    task automatic push(input logic we, input int a, input logic [DW-1:0] d,
                        input int gap, input string tag);
        xact_t x;
        x.we = we; x.addr = AW'(a); x.data = d; x.gap = gap; x.tag = tag;
        exp_q.push_back(x);
    endtask

    // add or NOR: fetch, then operand read
    task automatic ex_alu(input int pc, input int a);
        push(1'b0, pc, '0, prev_gap, "R7");
        push(1'b0, a, '0, 1, "R7");
        prev_gap = 33;
    endtask

    // store: fetch, then write of the expected accumulator
    task automatic ex_store(input int pc, input int a, input logic [DW-1:0] v, input string tag);
        push(1'b0, pc, '0, prev_gap, "R7");
        push(1'b1, a, v, 1, tag);
        prev_gap = 1;
    endtask

    task automatic ex_jump(input int pc);
        push(1'b0, pc, '0, prev_gap, "R6");
        prev_gap = 2;
    endtask

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // memory model and scoreboard monitor; wait states vary 1..3 per access (R9)
    initial begin
        int wc = 0;
        int gap = 0;
        int idx = 0;
        mem_ready = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst) begin
                mem_ready = 1'b0; wc = 0; gap = 0;
            end else begin
                if (mem_ready) begin
                    mem_ready = 1'b0; wc = 0;
                end
                if (!mem_req) begin
                    gap++;
                end else begin
                    wc++;
                    if (wc == 1 + (idx % 3)) begin
                        if (!done) begin
                            xact_t e;
                            e = exp_q.pop_front();
                            check(mem_we == e.we && mem_addr == e.addr, e.tag,
                                  "access kind/address (R2/R7/R9)",
                                  {33'd0, mem_we, mem_addr}, {33'd0, e.we, e.addr});
                            if (e.we)
                                check(mem_wdata == e.data, e.tag, "write data",
                                      {32'd0, mem_wdata}, {32'd0, e.data});
                            if (e.gap >= 0)
                                check(gap == e.gap, "R8", "idle gap before access",
                                      64'(gap), 64'(e.gap));
                            if (exp_q.size() == 0) done = 1'b1;
                        end
                        if (mem_addr < MEM_N) begin
                            mem_rdata = mem[mem_addr[5:0]];
                            if (mem_we) mem[mem_addr[5:0]] = mem_wdata;
                        end else begin
                            check(1'b0, "R7", "address outside test memory",
                                  64'(mem_addr), 64'(MEM_N));
                        end
                        mem_ready = 1'b1;
                        gap = 0;
                        idx++;
                    end
                end
            end
        end
    end

    initial begin
        int cyc = 0;
        for (int i = 0; i < MEM_N; i++) mem[i] = '0;
        // opcodes (R2): 00 add, 01 NOR, 10 store, 11 jump-if-negative
        mem[0]  = enc(2'b00, 40);
        mem[1]  = enc(2'b00, 41);
        mem[2]  = enc(2'b10, 50);
        mem[3]  = enc(2'b00, 42);
        mem[4]  = enc(2'b10, 51);
        mem[5]  = enc(2'b11, 20);
        mem[6]  = enc(2'b01, 43);
        mem[7]  = enc(2'b10, 52);
        mem[8]  = enc(2'b11, 12);
        mem[9]  = enc(2'b10, 53);
        mem[12] = enc(2'b01, 44);
        mem[13] = enc(2'b00, 45);
        mem[14] = enc(2'b00, 46);
        mem[15] = enc(2'b10, 54);
        mem[16] = enc(2'b11, 5);
        mem[17] = enc(2'b01, 47);
        mem[18] = enc(2'b10, 55);
        mem[19] = enc(2'b11, 19);
        mem[40] = 32'h7FFF_FFFF;
        mem[41] = 32'h0000_0001;
        mem[42] = 32'h8000_0000;
        mem[43] = 32'h0F0F_00FF;
        mem[44] = 32'hFFFF_FFFF;
        mem[45] = 32'h1234_5678;
        mem[46] = 32'h1111_1111;
        mem[47] = 32'h0000_0000;
        for (int i = 50; i < 56; i++) mem[i] = 32'hA5A5_A5A5;

        ex_alu(0, 40);
        ex_alu(1, 41);
        ex_store(2, 50, 32'h8000_0000, "R3");   // carry ripples through all bits
        ex_alu(3, 42);
        ex_store(4, 51, 32'h0000_0000, "R3");   // carry out of bit 31 dropped
        ex_jump(5);                              // not taken, acc = 0
        ex_alu(6, 43);
        ex_store(7, 52, 32'hF0F0_FF00, "R4");
        ex_jump(8);                              // taken to 12 (R6)
        ex_alu(12, 44);
        ex_alu(13, 45);
        ex_alu(14, 46);
        ex_store(15, 54, 32'h2345_6789, "R5");  // acc kept across stores
        ex_jump(16);                             // positive, not taken
        ex_alu(17, 47);
        ex_store(18, 55, 32'hDCBA_9876, "R4");
        ex_jump(19);
        ex_jump(19);

        repeat (4) @(negedge clk);
        check(mem_req == 1'b1 && mem_we == 1'b0, "R1", "request during reset",
              {62'd0, mem_req, mem_we}, 64'd2);
        check(mem_addr == '0, "R1", "fetch address during reset",
              64'(mem_addr), 64'd0);
        check(mem_wdata == '0, "R1", "accumulator during reset",
              64'(mem_wdata), 64'd0);
        rst = 1'b0;

        while (!done && cyc < WATCHDOG) begin
            @(negedge clk);
            cyc++;
        end
        check(done, "R7", "watchdog: scoreboard not drained",
              64'(exp_q.size()), 64'd0);

        repeat (4) @(negedge clk);
        check(mem[53] == 32'hA5A5_A5A5, "R6", "store skipped by taken jump",
              64'(mem[53]), 64'hA5A5_A5A5);
        check(mem[50] == 32'h8000_0000, "R3", "memory word 50",
              64'(mem[50]), 64'h8000_0000);
        check(mem[51] == 32'h0000_0000, "R3", "memory word 51",
              64'(mem[51]), 64'h0);
        check(mem[52] == 32'hF0F0_FF00, "R4", "memory word 52",
              64'(mem[52]), 64'hF0F0_FF00);
        check(mem[54] == 32'h2345_6789, "R5", "memory word 54",
              64'(mem[54]), 64'h2345_6789);
        check(mem[55] == 32'hDCBA_9876, "R4", "memory word 55",
              64'(mem[55]), 64'hDCBA_9876);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule